// File: doc/BRIEF.md
# Debug Bus Block-Access Engine

This engine lets a debug port move data to and from the system bus without help from the processor. A debug host writes a start address into the address register. It then writes a control word that names the direction, the transfer size and a beat count, and sets the start bit. The engine then runs one bus transfer per beat. After each beat the address steps forward by the transfer size and the count drops by one.

For block reads, the host collects each beat's data from the data register. For block writes, it supplies each further beat's data there. The engine paces itself on those data-register accesses. It raises a done flag when the count reaches zero.

A bus error ends the access at once, with no retry. The error sets a sticky error flag and posts a fixed 15-bit error message on a valid/ready output. A control write that arrives mid-block takes effect only at the next beat boundary. It either restarts a fresh access from the current address or simply stops the block.

Top module: `dbgBusEngine`

## Requirements
- R1: After reset the control register reads zero, no bus request is raised and no message is valid.
- R2: Register select 0 is control, 1 is address and 2 is data. The control word holds start in bit 31, read direction (1 = read) in bit 30, size in bits 29:28 and the beat count in bits 15:2. Bit 1 reads back the error flag and bit 0 reads back the done flag. Bit 31 reads back as busy. Writing the control word with start set raises a bus request at the address register, with the programmed size. A read beat's data is then readable at register 2.
- R3: Each completed beat advances the address by 1, 2 or 4 bytes for size codes 0, 1 and 2 (code 3 steps by 4), and lowers the count by one.
- R4: In a block read, no further beat is requested until the data register has been read. When the count reaches zero the done flag sets and busy clears.
- R5: In a block write, the first beat drives the data already in the data register. Each later beat waits for a new write to the data register.
- R6: A raised bus request keeps its address, size and write data until the bus answers with ready or error.
- R7: A bus error drops the request with no retry. It clears busy, sets the error flag, leaves the done flag clear and leaves the address unchanged.
- R8: A bus error raises msgValid with msgWord = {5'b00011, 4-bit source ID, 6'b001000}, MSB first. The word is held until msgReady is seen.
- R9: The error flag stays set until the control register is written, and that write clears both the error and done flags.
- R10: A control write between beats takes effect at once. With start set, it begins a new access from the current address with the new count and size. With start clear, the block ends.
- R11: A control write while a beat is outstanding does not cut that beat short. The beat completes, advancing the address and capturing its data, and then the write takes effect.
- R12: Starting with a count of zero sets the done flag immediately and issues no bus transfer.
- R13: Writes to the address or data register while a beat is outstanding are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (paces block reads) |
| regAddr | input | 2 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| busReq | output | 1 | Bus transfer request |
| busWe | output | 1 | Bus write (1) or read (0) |
| busAddr | output | 32 | Bus byte address |
| busSize | output | 2 | Bus size code |
| busWdata | output | 32 | Bus write data |
| busRdata | input | 32 | Bus read data |
| busReady | input | 1 | Bus transfer completed |
| busErr | input | 1 | Bus transfer error |
| msgValid | output | 1 | Error message valid |
| msgWord | output | 15 | Error message word |
| msgReady | input | 1 | Error message accepted |

## Verification
The hardest case to reach is a control write that lands while a beat is still on the bus. The engine must hold that write until the beat finishes and then apply it on top of the beat's address step. The bench drives this case by raising a request and withholding busReady. It issues the control write during that stall, then checks that the request stays up. After the bus answers, it checks the advanced address, the captured data and the new state. The same stall window is used to show that address and data writes do not disturb an outstanding transfer.

// File: rtl/dbgEnginePkg.sv
package dbgEnginePkg;
  localparam int CNT_W = 14;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} engState_t;

  typedef struct packed {
    logic             go;
    logic             rd;
    logic [1:0]       size;
    logic [CNT_W-1:0] cnt;
  } cfg_t;

  typedef struct packed {
    logic ldCfg;
    logic advance;
    logic capture;
    logic lockRegs;
  } dpStrobe_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
endpackage

// File: rtl/dbgEngControl.sv
module dbgEngControl
  import dbgEnginePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regAddr,
  input  cfg_t        cfgIn,
  input  logic        busReady,
  input  logic        busErr,
  input  logic        lastBeat,
  input  logic        readMode,
  input  logic        msgReady,
  output dpStrobe_t   strobe,
  output cfg_t        cfgOut,
  output logic        busReq,
  output logic        stGo,
  output logic        stErr,
  output logic        stDv,
  output logic        msgValid
);
  engState_t state, stateN;
  logic errN, dvN;
  logic pendV;
  cfg_t pendCfg;
  logic ctrlWr, dataRd, dataWr, haveCfg, applyNow, beatOk, beatBad;
  cfg_t useCfg;

  always_comb begin
    ctrlWr   = regWrEn && (regAddr == SEL_CTRL);
    dataRd   = regRdEn && (regAddr == SEL_DATA);
    dataWr   = regWrEn && (regAddr == SEL_DATA);
    haveCfg  = ctrlWr || pendV;
    useCfg   = ctrlWr ? cfgIn : pendCfg;
    beatBad  = (state == ST_ISSUE) && busErr;
    beatOk   = (state == ST_ISSUE) && busReady && !busErr;
    applyNow = haveCfg && ((state != ST_ISSUE) || beatOk || beatBad);
  end

  always_comb begin
    strobe.ldCfg    = applyNow;
    strobe.advance  = beatOk;
    strobe.capture  = beatOk && readMode;
    strobe.lockRegs = (state == ST_ISSUE);
    cfgOut          = useCfg;
    busReq          = (state == ST_ISSUE);
    stGo            = (state != ST_IDLE);
  end

  always_comb begin
    stateN = state;
    errN   = stErr;
    dvN    = stDv;
    case (state)
      ST_ISSUE: begin
        if (beatBad) begin
          stateN = ST_IDLE;
          errN   = 1'b1;
        end else if (beatOk) begin
          if (lastBeat) begin
            stateN = ST_IDLE;
            dvN    = 1'b1;
          end else begin
            stateN = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (readMode ? dataRd : dataWr) stateN = ST_ISSUE;
      end
      default: ;
    endcase
    if (applyNow) begin
      errN = 1'b0;
      dvN  = 1'b0;
      if (!useCfg.go) begin
        stateN = ST_IDLE;
      end else if (useCfg.cnt == '0) begin
        stateN = ST_IDLE;
        dvN    = 1'b1;
      end else begin
        stateN = ST_ISSUE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stErr    <= 1'b0;
      stDv     <= 1'b0;
      pendV    <= 1'b0;
      pendCfg  <= '0;
      msgValid <= 1'b0;
    end else begin
      state <= stateN;
      stErr <= errN;
      stDv  <= dvN;
      if (applyNow) begin
        pendV <= 1'b0;
      end else if (ctrlWr) begin
        pendV   <= 1'b1;
        pendCfg <= cfgIn;
      end
      if (beatBad) msgValid <= 1'b1;
      else if (msgReady) msgValid <= 1'b0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busReady && !busErr |=> busReq); // R6
  AST_ERR_NO_RETRY: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busErr && !haveCfg |=> !busReq && stErr && !stDv); // R7
  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid); // R8
  AST_DONE_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    stDv |-> !busReq); // R4
endmodule

// File: rtl/dbgEngDatapath.sv
module dbgEngDatapath
  import dbgEnginePkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              cfgRd,
  input  logic [1:0]        cfgSize,
  input  logic [CNT_W-1:0]  cfgCnt,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              stGo,
  input  logic              stErr,
  input  logic              stDv,
  output logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [1:0]        busSize,
  output logic              readMode,
  output logic              lastBeat
);
  localparam int PAD_W = DATA_W - 4 - CNT_W - 2;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [CNT_W-1:0]  cntReg;
  logic [1:0]        sizeReg;
  logic              rdReg;
  logic [2:0]        step;

  always_comb begin
    case (sizeReg)
      2'd0:    step = 3'd1;
      2'd1:    step = 3'd2;
      default: step = 3'd4;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      cntReg  <= '0;
      sizeReg <= '0;
      rdReg   <= 1'b0;
    end else begin
      if (strobe.ldCfg) begin
        sizeReg <= cfgSize;
        rdReg   <= cfgRd;
        cntReg  <= cfgCnt;
      end else if (strobe.advance) begin
        cntReg <= cntReg - 1'b1;
      end
      if (strobe.advance)
        addrReg <= addrReg + {{(ADDR_W-3){1'b0}}, step};
      else if (regWrEn && regAddr == SEL_ADDR && !strobe.lockRegs)
        addrReg <= regWrData[ADDR_W-1:0];
      if (strobe.capture)
        dataReg <= busRdata;
      else if (regWrEn && regAddr == SEL_DATA && !strobe.lockRegs)
        dataReg <= regWrData;
    end
  end

  always_comb begin
    busAddr   = addrReg;
    busWdata  = dataReg;
    busSize   = sizeReg;
    readMode  = rdReg;
    lastBeat  = (cntReg == {{(CNT_W-1){1'b0}}, 1'b1});
    regRdData = '0;
    case (regAddr)
      SEL_CTRL: regRdData = {stGo, rdReg, sizeReg, {PAD_W{1'b0}}, cntReg, stErr, stDv};
      SEL_ADDR: regRdData[ADDR_W-1:0] = addrReg;
      SEL_DATA: regRdData = dataReg;
      default:  regRdData = '0;
    endcase
  end

  AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lockRegs && !strobe.advance |=> addrReg == $past(addrReg)); // R13
  AST_NO_CNT_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> cntReg != '0); // R3
endmodule

// File: rtl/dbgBusEngine.sv
module dbgBusEngine
  import dbgEnginePkg::*;
#(
  parameter int          ADDR_W = 32,
  parameter int          DATA_W = 32,
  parameter logic [3:0]  SRC_ID = 4'h5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              busReq,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  input  logic              busErr,
  output logic              msgValid,
  output logic [14:0]       msgWord,
  input  logic              msgReady
);
  localparam logic [4:0] ERR_CODE = 5'b00011;
  localparam logic [5:0] XFER_CODE = 6'b001000;

  dpStrobe_t strobe;
  cfg_t      cfgIn, cfgOut;
  logic      stGo, stErr, stDv, readMode, lastBeat;

  always_comb begin
    cfgIn.go   = regWrData[31];
    cfgIn.rd   = regWrData[30];
    cfgIn.size = regWrData[29:28];
    cfgIn.cnt  = regWrData[CNT_W+1:2];
    busWe      = !readMode;
    msgWord    = {ERR_CODE, SRC_ID, XFER_CODE};
  end

  dbgEngControl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .cfgIn(cfgIn), .busReady(busReady), .busErr(busErr),
    .lastBeat(lastBeat), .readMode(readMode), .msgReady(msgReady),
    .strobe(strobe), .cfgOut(cfgOut), .busReq(busReq), .stGo(stGo),
    .stErr(stErr), .stDv(stDv), .msgValid(msgValid)
  );

  dbgEngDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgRd(cfgOut.rd),
    .cfgSize(cfgOut.size), .cfgCnt(cfgOut.cnt), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .busRdata(busRdata),
    .stGo(stGo), .stErr(stErr), .stDv(stDv), .regRdData(regRdData),
    .busAddr(busAddr), .busWdata(busWdata), .busSize(busSize),
    .readMode(readMode), .lastBeat(lastBeat)
  );

  AST_MSG_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busErr |=> msgValid); // R8
endmodule

// File: tb/sim_dbgBusEngine.sv
module sim_dbgBusEngine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        busReq, busWe;
  logic [31:0] busAddr, busWdata;
  logic [1:0]  busSize;
  logic [31:0] busRdata = '0;
  logic        busReady = 1'b0, busErr = 1'b0;
  logic        msgValid;
  logic [14:0] msgWord;
  logic        msgReady = 1'b0;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dbgBusEngine u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .busReq(busReq), .busWe(busWe), .busAddr(busAddr), .busSize(busSize),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .busErr(busErr), .msgValid(msgValid), .msgWord(msgWord), .msgReady(msgReady)
  );

  // vector: [47:46] size, [45:32] count, [31:0] start address
  localparam logic [47:0] VEC [4] = '{
    {2'd2, 14'd3, 32'h0000_0100},
    {2'd1, 14'd2, 32'h0000_0201},
    {2'd0, 14'd4, 32'h0000_03FF},
    {2'd3, 14'd1, 32'h0000_0040}
  };

  function automatic logic [31:0] mkCtrl(logic go, logic rd, logic [1:0] sz, logic [13:0] cnt);
    return {go, rd, sz, 12'b0, cnt, 2'b00};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [31:0] v);
    regRdEn = 1'b1; regAddr = a;
    #1 v = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [31:0] v);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic waitReq(string req);
    int n = 0;
    while (!busReq && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(req, {31'b0, busReq}, 32'd1);
  endtask

  task automatic beat(logic [31:0] rdata);
    busRdata = rdata; busReady = 1'b1;
    @(negedge clk);
    busReady = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(2'd0, v); chk("R1 ctrl", v, 32'h0);
    chk("R1 busReq", {31'b0, busReq}, 32'd0);
    chk("R1 msgValid", {31'b0, msgValid}, 32'd0);

    // table of block reads (R2, R3, R4)
    for (int i = 0; i < 4; i++) begin
      logic [1:0]  sz = VEC[i][47:46];
      logic [13:0] cnt = VEC[i][45:32];
      logic [31:0] a0 = VEC[i][31:0];
      logic [31:0] st = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
      wrReg(2'd1, a0);
      wrReg(2'd0, mkCtrl(1'b1, 1'b1, sz, cnt));
      for (int b = 0; b < int'(cnt); b++) begin
        waitReq("R2 request");
        chk("R3 beat address", busAddr, a0 + st * b);
        chk("R2 bus size", {30'b0, busSize}, {30'b0, sz});
        chk("R2 read direction", {31'b0, busWe}, 32'd0);
        beat(32'hC0DE_0000 + a0 + b);
        peek(2'd0, v);
        chk("R3 count", {18'b0, v[15:2]}, 32'(int'(cnt) - b - 1));
        if (b < int'(cnt) - 1) begin
          repeat (3) @(negedge clk);
          chk("R4 waits for data read", {31'b0, busReq}, 32'd0);
        end
        rdReg(2'd2, v);
        chk("R2 read data", v, 32'hC0DE_0000 + a0 + b);
      end
      peek(2'd0, v);
      chk("R4 done set busy clear", {30'b0, v[31], v[0]}, 32'd1);
      peek(2'd1, v);
      chk("R3 final address", v, a0 + st * cnt);
    end

    // R5, R6, R13 block write
    wrReg(2'd2, 32'hAAAA_0001);
    wrReg(2'd1, 32'h800);
    wrReg(2'd0, mkCtrl(1'b1, 1'b0, 2'd2, 14'd2));
    chk("R5 first beat immediate", {31'b0, busReq}, 32'd1);
    chk("R5 write direction", {31'b0, busWe}, 32'd1);
    chk("R5 first data", busWdata, 32'hAAAA_0001);
    wrReg(2'd1, 32'hDEAD);
    wrReg(2'd2, 32'hBAD0_BAD0);
    chk("R6 request held", {31'b0, busReq}, 32'd1);
    chk("R13 address write ignored", busAddr, 32'h800);
    chk("R13 data write ignored", busWdata, 32'hAAAA_0001);
    beat(32'h0);
    repeat (3) @(negedge clk);
    chk("R5 waits for data write", {31'b0, busReq}, 32'd0);
    wrReg(2'd2, 32'hAAAA_0002);
    chk("R5 second beat", {31'b0, busReq}, 32'd1);
    chk("R5 second address", busAddr, 32'h804);
    chk("R5 second data", busWdata, 32'hAAAA_0002);
    beat(32'h0);
    peek(2'd0, v);
    chk("R5 done", {30'b0, v[31], v[0]}, 32'd1);

    // R12 zero count
    wrReg(2'd0, mkCtrl(1'b1, 1'b1, 2'd2, 14'd0));
    peek(2'd0, v);
    chk("R12 done at once", {30'b0, v[31], v[0]}, 32'd1);
    chk("R12 no transfer", {31'b0, busReq}, 32'd0);

    // R7, R8, R9 bus error
    wrReg(2'd1, 32'h900);
    wrReg(2'd0, mkCtrl(1'b1, 1'b1, 2'd2, 14'd3));
    waitReq("R7 request");
    busErr = 1'b1;
    @(negedge clk);
    busErr = 1'b0;
    chk("R7 no retry", {31'b0, busReq}, 32'd0);
    peek(2'd0, v);
    chk("R7 go/err/done", {29'b0, v[31], v[1], v[0]}, 32'b010);
    peek(2'd1, v);
    chk("R7 address kept", v, 32'h900);
    chk("R8 msg valid", {31'b0, msgValid}, 32'd1);
    chk("R8 msg word", {17'b0, msgWord}, {17'b0, 5'b00011, 4'h5, 6'b001000});
    repeat (2) @(negedge clk);
    chk("R8 msg held", {31'b0, msgValid}, 32'd1);
    msgReady = 1'b1;
    @(negedge clk);
    msgReady = 1'b0;
    chk("R8 msg accepted", {31'b0, msgValid}, 32'd0);
    peek(2'd0, v);
    chk("R9 err sticky", {31'b0, v[1]}, 32'd1);
    wrReg(2'd0, 32'h0);
    peek(2'd0, v);
    chk("R9 err cleared", {31'b0, v[1]}, 32'd0);

    // R10 rewrite between beats
    wrReg(2'd1, 32'hA00);
    wrReg(2'd0, mkCtrl(1'b1, 1'b1, 2'd2, 14'd3));
    waitReq("R10 request");
    beat(32'h1);
    wrReg(2'd0, mkCtrl(1'b1, 1'b1, 2'd1, 14'd2));
    chk("R10 restart request", {31'b0, busReq}, 32'd1);
    chk("R10 restart address", busAddr, 32'hA04);
    chk("R10 restart size", {30'b0, busSize}, 32'd1);
    peek(2'd0, v);
    chk("R10 restart count", {18'b0, v[15:2]}, 32'd2);
    beat(32'h2);
    wrReg(2'd0, 32'h0);
    peek(2'd0, v);
    chk("R10 stopped", {30'b0, v[31], v[0]}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R10 no request", {31'b0, busReq}, 32'd0);
    peek(2'd1, v);
    chk("R10 address", v, 32'hA06);

    // R11 rewrite while a beat is outstanding
    wrReg(2'd1, 32'hB00);
    wrReg(2'd0, mkCtrl(1'b1, 1'b1, 2'd2, 14'd3));
    wrReg(2'd0, 32'h0);
    chk("R11 beat not cut", {31'b0, busReq}, 32'd1);
    chk("R11 address stable", busAddr, 32'hB00);
    beat(32'h1234_5678);
    chk("R11 then stopped", {31'b0, busReq}, 32'd0);
    peek(2'd0, v);
    chk("R11 busy clear", {31'b0, v[31]}, 32'd0);
    peek(2'd1, v);
    chk("R11 address advanced", v, 32'hB04);
    peek(2'd2, v);
    chk("R11 data captured", v, 32'h1234_5678);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule